// File: doc/BRIEF.md
# Grouped Glitch-Free Clock Gate

This block sits between a clock generator and the clock pins of a board-level clock buffer. It gates thirteen running clocks: four processor clocks, seven bus clocks, a graphics clock and a floppy-disk clock. A 2-bit group stop code stops whole groups in a fixed priority order. Processor clocks 0 and 1 go first, then processor clocks 2 and 3, then the bus and fixed-rate clocks. A per-output enable vector, loaded by a serial control register outside this block, can stop any single output on its own. An output runs only when both its group and its own enable bit allow it.

Each gated output stops and restarts cleanly. The enable for an output is sampled on falling edges of that output's own source clock through a short synchroniser, and the result is ANDed with the clock. Every high pulse therefore has full width, and a stopped output rests low. The keyboard and reference clocks are wired straight through and never stop.

Top module: `gclk_group_gate`

## Requirements
- R1: Stop code 2'b00 holds every gated output low: all processor clocks, all bus clocks, the graphics clock and the floppy clock.
- R2: Stop code 2'b01 holds all four processor clocks low, while the bus, graphics and floppy clocks keep running.
- R3: Stop code 2'b10 holds processor clocks 0 and 1 low, while processor clocks 2 and 3, the bus clocks and the graphics and floppy clocks keep running.
- R4: Stop code 2'b11 lets every gated output run, subject only to its enable bit.
- R5: Enable vector bit positions are [3:0] processor clocks 0 to 3, [10:4] bus clocks 0 to 6, [11] graphics and [12] floppy. A 0 bit stops that output whatever the stop code is. A 1 bit lets it run when its group runs.
- R6: The keyboard and reference outputs always follow their inputs, whatever the stop code, the enable vector or the reset.
- R7: A stopped output rests at logic low and shows no high level at all while stopped.
- R8: No gated output produces a shortened pulse. Every high pulse lasts at least the source clock's high phase, and every low pulse lasts at least the source clock's low phase.
- R9: With the default 2-stage synchroniser, a change in an output's run condition that is stable before a falling edge of its source clock has taken effect after the third such falling edge.
- R10: While a source clock is frozen, its gated outputs hold their level, even when the stop code or the enable vector changes.
- R11: While rst_n is low, every gated output is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| rst_n | input | 1 | Active-low asynchronous reset; closes every gate |
| proc_clk_i | input | 1 | Source clock for the processor outputs |
| bus_clk_i | input | 1 | Source clock for the bus outputs |
| gfx_clk_i | input | 1 | Source clock for the graphics output |
| fdd_clk_i | input | 1 | Source clock for the floppy output |
| kbd_clk_i | input | 1 | Keyboard clock, passed through |
| ref_clk_i | input | 1 | Reference clock, passed through |
| stop_code_i | input | 2 | Group stop code (see R1 to R4) |
| ser_en_i | input | N_PROC+N_BUS+2 | Per-output enable vector (see R5) |
| proc_clk_o | output | N_PROC | Gated processor clocks |
| bus_clk_o | output | N_BUS | Gated bus clocks |
| gfx_clk_o | output | 1 | Gated graphics clock |
| fdd_clk_o | output | 1 | Gated floppy clock |
| kbd_clk_o | output | 1 | Keyboard clock output |
| ref_clk_o | output | 1 | Reference clock output |

## Verification
The state of each gate is its synchroniser chain. A wrong bit there shows as an output that toggles when it should rest low, or that stays dark when it should run, within at most three periods of that output's source clock. A last stage that changes while the clock is high shows at once as a shortened high pulse. The pulse-width monitors catch this on the very edge where it happens. A wrong decode of the stop code shows at the next group boundary as the wrong set of toggling outputs.

// File: rtl/gclk_pkg.sv
`timescale 1ns/1ps
package gclk_pkg;
   typedef enum logic [1:0] {
      STOP_EVERYTHING = 2'b00,
      STOP_ALL_PROC   = 2'b01,
      STOP_PROC_LOW   = 2'b10,
      RUN_EVERYTHING  = 2'b11
   } stop_code_t;

   typedef struct packed {
      logic proc_a;   // processor clocks in the lower half
      logic proc_b;   // processor clocks in the upper half
      logic bus;
      logic fixed;    // graphics and floppy
   } group_run_t;
endpackage

// File: rtl/gclk_stop_decode.sv
`timescale 1ns/1ps
module gclk_stop_decode
   import gclk_pkg::*;
(
   input  logic [1:0] code_i,
   output group_run_t run_o
);
   stop_code_t code;
   assign code = stop_code_t'(code_i);

   always_comb begin
      run_o = '0;
      unique case (code)
         STOP_EVERYTHING: run_o = '0;
         STOP_ALL_PROC:   run_o = '{proc_a: 1'b0, proc_b: 1'b0, bus: 1'b1, fixed: 1'b1};
         STOP_PROC_LOW:   run_o = '{proc_a: 1'b0, proc_b: 1'b1, bus: 1'b1, fixed: 1'b1};
         RUN_EVERYTHING:  run_o = '1;
         default:         run_o = '0;
      endcase
   end

   // Groups stop in a strict order: a later group never stops while an earlier one runs.
   always_comb begin
      if (!$isunknown(code_i)) begin
         p_stop_priority_r2: assert ((run_o.proc_b || !run_o.proc_a) &&
                                     (run_o.bus || !run_o.proc_b) &&
                                     (run_o.bus == run_o.fixed))
            else $error("group stop order violated");
         p_run_all_r4: assert (code_i != 2'b11 || (&run_o))
            else $error("run-all code left a group stopped");
      end
   end
endmodule

// File: rtl/gclk_gate.sv
`timescale 1ns/1ps
module gclk_gate #(
   parameter int SYNC_STAGES = 2
) (
   input  logic clk_i,
   input  logic rst_n,
   input  logic en_req_i,
   output logic clk_o
);
   if (SYNC_STAGES < 2) begin : g_bad_depth
      $error("gclk_gate: SYNC_STAGES must be at least 2");
   end

   logic [SYNC_STAGES-1:0] sync_q;

   // Falling-edge sampling: the last stage only moves while clk_i is low.
   always_ff @(negedge clk_i or negedge rst_n) begin
      if (!rst_n) sync_q <= '0;
      else        sync_q <= {sync_q[SYNC_STAGES-2:0], en_req_i};
   end

   assign clk_o = clk_i & sync_q[SYNC_STAGES-1];

   if (SYNC_STAGES == 2) begin : g_latency_chk
      p_open_latency_r9: assert property (@(negedge clk_i) disable iff (!rst_n)
         (en_req_i && $past(en_req_i) && $past(rst_n)) |=> sync_q[SYNC_STAGES-1])
         else $error("gate failed to open in time");
      p_close_latency_r9: assert property (@(negedge clk_i) disable iff (!rst_n)
         (!en_req_i && !$past(en_req_i) && $past(rst_n)) |=> !sync_q[SYNC_STAGES-1])
         else $error("gate failed to close in time");
   end
endmodule

// File: rtl/gclk_group_gate.sv
`timescale 1ns/1ps
module gclk_group_gate
   import gclk_pkg::*;
#(
   parameter int N_PROC      = 4,
   parameter int N_BUS       = 7,
   parameter int SYNC_STAGES = 2
) (
   input  logic                      rst_n,
   input  logic                      proc_clk_i,
   input  logic                      bus_clk_i,
   input  logic                      gfx_clk_i,
   input  logic                      fdd_clk_i,
   input  logic                      kbd_clk_i,
   input  logic                      ref_clk_i,
   input  logic [1:0]                stop_code_i,
   input  logic [N_PROC+N_BUS+1:0]   ser_en_i,
   output logic [N_PROC-1:0]         proc_clk_o,
   output logic [N_BUS-1:0]          bus_clk_o,
   output logic                      gfx_clk_o,
   output logic                      fdd_clk_o,
   output logic                      kbd_clk_o,
   output logic                      ref_clk_o
);
   localparam int N_OUT   = N_PROC + N_BUS + 2;
   localparam int N_PROCA = N_PROC / 2;
   localparam int IDX_GFX = N_PROC + N_BUS;
   localparam int IDX_FDD = N_OUT - 1;

   if (N_PROC < 2 || (N_PROC % 2) != 0) begin : g_bad_proc
      $error("gclk_group_gate: N_PROC must be even and at least 2");
   end
   if (N_BUS < 1) begin : g_bad_bus
      $error("gclk_group_gate: N_BUS must be at least 1");
   end

   group_run_t         run;
   logic [N_OUT-1:0]   raw_clk;
   logic [N_OUT-1:0]   grp_run;
   logic [N_OUT-1:0]   gate_req;
   logic [N_OUT-1:0]   gated;

   gclk_stop_decode u_decode (
      .code_i (stop_code_i),
      .run_o  (run)
   );

   for (genvar i = 0; i < N_OUT; i++) begin : g_out
      if (i < N_PROCA) begin : g_proc_a
         assign raw_clk[i] = proc_clk_i;
         assign grp_run[i] = run.proc_a;
      end else if (i < N_PROC) begin : g_proc_b
         assign raw_clk[i] = proc_clk_i;
         assign grp_run[i] = run.proc_b;
      end else if (i < IDX_GFX) begin : g_bus
         assign raw_clk[i] = bus_clk_i;
         assign grp_run[i] = run.bus;
      end else if (i == IDX_GFX) begin : g_gfx
         assign raw_clk[i] = gfx_clk_i;
         assign grp_run[i] = run.fixed;
      end else begin : g_fdd
         assign raw_clk[i] = fdd_clk_i;
         assign grp_run[i] = run.fixed;
      end

      // Group and serial controls combine: either one can stop the output.
      assign gate_req[i] = grp_run[i] & ser_en_i[i];

      gclk_gate #(.SYNC_STAGES(SYNC_STAGES)) u_gate (
         .clk_i    (raw_clk[i]),
         .rst_n    (rst_n),
         .en_req_i (gate_req[i]),
         .clk_o    (gated[i])
      );
   end

   assign proc_clk_o = gated[N_PROC-1:0];
   assign bus_clk_o  = gated[IDX_GFX-1:N_PROC];
   assign gfx_clk_o  = gated[IDX_GFX];
   assign fdd_clk_o  = gated[IDX_FDD];
   assign kbd_clk_o  = kbd_clk_i;
   assign ref_clk_o  = ref_clk_i;
endmodule

// File: tb/gclk_group_gate_tb.sv
`timescale 1ns/1ps
module gclk_group_gate_tb;
   localparam int N_OUT = 13;

   logic        rst_n = 1'b0;
   logic        proc_clk = 1'b0, bus_clk = 1'b0, gfx_clk = 1'b0, fdd_clk = 1'b0;
   logic        kbd_clk = 1'b0, ref_clk = 1'b0;
   logic        frz = 1'b0;
   logic [1:0]  code = 2'b11;
   logic [12:0] ser_en = '1;
   logic [3:0]  proc_o;
   logic [6:0]  bus_o;
   logic        gfx_o, fdd_o, kbd_o, ref_o;
   wire  [12:0] obs = {fdd_o, gfx_o, bus_o, proc_o};

   int  n_checks = 0, n_fail = 0;
   bit  done = 1'b0, mon_on = 1'b0;

   // processor source runs at 200 MHz; it is the only one that can be frozen
   always #2.5 if (!frz) proc_clk = ~proc_clk;
   always #5.0 bus_clk = ~bus_clk;
   always #3.0 gfx_clk = ~gfx_clk;
   always #7.0 fdd_clk = ~fdd_clk;
   always #10.0 kbd_clk = ~kbd_clk;
   always #15.0 ref_clk = ~ref_clk;

   gclk_group_gate u_dut (
      .rst_n(rst_n), .proc_clk_i(proc_clk), .bus_clk_i(bus_clk),
      .gfx_clk_i(gfx_clk), .fdd_clk_i(fdd_clk), .kbd_clk_i(kbd_clk),
      .ref_clk_i(ref_clk), .stop_code_i(code), .ser_en_i(ser_en),
      .proc_clk_o(proc_o), .bus_clk_o(bus_o), .gfx_clk_o(gfx_o),
      .fdd_clk_o(fdd_o), .kbd_clk_o(kbd_o), .ref_clk_o(ref_o));

   function automatic real half_of(input int g);
      if (g < 4)        return 2.5;
      else if (g < 11)  return 5.0;
      else if (g == 11) return 3.0;
      else              return 7.0;
   endfunction

   // R8 pulse-width monitors
   int  runt_hi [N_OUT];
   int  runt_lo [N_OUT];
   real t_up [N_OUT];
   real t_dn [N_OUT];
   for (genvar g = 0; g < N_OUT; g++) begin : g_mon
      initial begin runt_hi[g] = 0; runt_lo[g] = 0; t_up[g] = -1.0; t_dn[g] = -1.0; end
      always @(posedge obs[g]) begin
         if (mon_on && t_dn[g] >= 0.0 && ($realtime - t_dn[g]) < half_of(g) - 0.05)
            runt_lo[g] = runt_lo[g] + 1;
         t_up[g] = $realtime;
      end
      always @(negedge obs[g]) begin
         if (mon_on && t_up[g] >= 0.0 && ($realtime - t_up[g]) < half_of(g) - 0.05)
            runt_hi[g] = runt_hi[g] + 1;
         t_dn[g] = $realtime;
      end
   end

   task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
      n_checks++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   // Sample every 1 ns for n steps; collect which outputs were seen high and low.
   task automatic watch(input int n, output logic [12:0] hi, output logic [12:0] lo,
                        output logic [3:0] pass_seen);
      hi = '0; lo = '0; pass_seen = '0;
      for (int s = 0; s < n; s++) begin
         #1;
         hi |= obs;
         lo |= ~obs;
         pass_seen |= {kbd_o, !kbd_o, ref_o, !ref_o};
         if (kbd_o != kbd_clk || ref_o != ref_clk) pass_seen[3] = 1'bx;
      end
   endtask

   // {stop code, enable vector, expected running mask}
   typedef struct packed { logic [1:0] c; logic [12:0] en; logic [12:0] run; } vec_t;
   localparam vec_t VECS [9] = '{
      '{2'b11, 13'h1FFF, 13'h1FFF},   // R4
      '{2'b10, 13'h1FFF, 13'h1FFC},   // R3
      '{2'b01, 13'h1FFF, 13'h1FF0},   // R2
      '{2'b00, 13'h1FFF, 13'h0000},   // R1
      '{2'b11, 13'h0AAA, 13'h0AAA},   // R5 restart from all stopped
      '{2'b10, 13'h1555, 13'h1554},   // R5 with R3
      '{2'b01, 13'h1F0F, 13'h1F00},   // R5 with R2
      '{2'b11, 13'h0000, 13'h0000},   // R5 all serial stops
      '{2'b11, 13'h1FFF, 13'h1FFF}    // R4 full restart
   };

   initial begin
      logic [12:0] hi, lo;
      logic [3:0]  ps;
      #0.3;
      // R11: outputs low during reset with everything requested to run
      #20;
      watch(30, hi, lo, ps);
      chk(hi == 13'h0, "R11 reset holds outputs low", 32'(hi), 32'h0);
      chk(ps === 4'hF, "R6 passthrough during reset", 32'(ps), 32'hF);
      rst_n = 1'b1;
      #100;
      mon_on = 1'b1;

      foreach (VECS[k]) begin
         code = VECS[k].c;
         ser_en = VECS[k].en;
         #60;
         watch(60, hi, lo, ps);
         chk(hi == VECS[k].run, $sformatf("R1-4/R5 vector %0d running mask", k), 32'(hi), 32'(VECS[k].run));
         chk((lo | VECS[k].run) == 13'h1FFF, $sformatf("R7 vector %0d stopped outputs low", k),
             32'(lo), 32'h1FFF);
         chk(ps === 4'hF, $sformatf("R6 vector %0d passthrough", k), 32'(ps), 32'hF);
      end

      // R9: stop latency on processor clock 0
      @(negedge proc_clk); #0.3;
      ser_en[0] = 1'b0;
      repeat (3) @(negedge proc_clk);
      #0.3;
      watch(20, hi, lo, ps);
      chk(hi[0] == 1'b0, "R9 stop within three falling edges", 32'(hi[0]), 32'h0);
      @(negedge proc_clk); #0.3;
      ser_en[0] = 1'b1;
      repeat (3) @(negedge proc_clk);
      #0.3;
      watch(5, hi, lo, ps);
      chk(hi[0] == 1'b1, "R9 start within three falling edges", 32'(hi[0]), 32'h1);

      // R10: freeze processor source while high, then try to stop an output
      @(posedge proc_clk); #0.3;
      frz = 1'b1;
      #1;
      ser_en[1] = 1'b0;
      code = 2'b10;
      watch(30, hi, lo, ps);
      chk(lo[3:0] == 4'h0, "R10 frozen outputs hold high", 32'(lo[3:0]), 32'h0);
      chk(hi[3:0] == 4'hF, "R10 frozen outputs unchanged", 32'(hi[3:0]), 32'hF);
      frz = 1'b0;
      #40;
      watch(20, hi, lo, ps);
      chk(hi[3:0] == 4'hC, "R10 stop applied after thaw (R3 and R5)", 32'(hi[3:0]), 32'hC);
      // freeze while low, request restart: outputs stay low
      @(negedge proc_clk); #0.3;
      frz = 1'b1;
      #1;
      code = 2'b11; ser_en = '1;
      watch(30, hi, lo, ps);
      chk(hi[3:0] == 4'h0, "R10 frozen-low outputs stay low", 32'(hi[3:0]), 32'h0);
      frz = 1'b0;
      #40;
      watch(20, hi, lo, ps);
      chk(hi == 13'h1FFF, "R4 all running after thaw", 32'(hi), 32'h1FFF);

      // R8: no shortened pulses anywhere during the run
      begin
         int sh = 0, sl = 0;
         for (int g = 0; g < N_OUT; g++) begin sh += runt_hi[g]; sl += runt_lo[g]; end
         chk(sh == 0, "R8 no short high pulses", 32'(sh), 32'h0);
         chk(sl == 0, "R8 no short low pulses", 32'(sl), 32'h0);
      end
      done = 1'b1;
      $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
      $finish;
   end

   initial begin
      #200000;
      if (!done) begin
         n_checks++;
         n_fail++;
         $display("FAIL watchdog: run did not complete actual=hung expected=done");
         $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
         $finish;
      end
   end
endmodule